// File: doc/BRIEF.md
# Byte Serial Port with Collision and Completion Flags

This block is a master-only synchronous serial port that moves one byte at a time. Software writes a byte into the transmit register. When the port is idle, that write loads the shift engine and starts a transfer. Eight bits go out most significant bit first on `spi_mosi`. Eight bits come in on `spi_miso` and are sampled on each rising `spi_sclk` edge. The serial clock runs at a fixed division of the system clock.

When the eighth bit has been sampled, the received byte lands in the receive buffer and a completion flag is raised. A write that arrives while a transfer is running does not disturb the shift engine. It raises a collision flag instead, and the rejected byte stays readable in the transmit register.

Each flag can be cleared in two ways:
- Writing a zero to its status bit.
- Reading the status register with the very next register access being the right data access.

Each flag drives its own interrupt line, which is gated by an enable bit. A receive buffer that is not read in time is simply overwritten, and nothing reports it.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, the status (0xAB), receive (0x95), transmit (0x94) and enable (0xAC) registers all read 0, and both interrupt outputs are low.
- R2: A transmit write while idle starts a transfer and sets status bit 0 (busy). Bits leave MSB first on `spi_mosi`. The receive byte is built MSB first from `spi_miso` samples taken on rising `spi_sclk`, so with `spi_miso` looped back to `spi_mosi` the receive register returns the byte sent.
- R3: `spi_sclk` is low when a transfer starts. Status bit 0 stays 1 through the 15*HALF-1 cycles after the starting write edge. At edge 15*HALF, bit 0 clears and status bit 1 (done) sets.
- R4: A transmit write while busy sets status bit 2 (collision). The transmit register then reads back the written byte, and the running transfer still delivers the original byte.
- R5: Writing the status register with bit 2 = 0 clears collision. Writing a 1 never sets a flag.
- R6: A status read followed directly by a transmit write clears collision.
- R7: Writing the status register with bit 1 = 0 clears done, but only if the receive register was read after done was last set.
- R8: A status read followed directly by a receive read clears done. Any other register access between the two cancels this clear path.
- R9: `irq_done` equals done AND enable bit 0. `irq_col` equals collision AND enable bit 1.
- R10: A completed transfer overwrites an unread receive byte, and no flag reports the loss.
- R11: Status bits 7 to 3 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe (drives read side effects) |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from `bus_addr` |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out, MSB first |
| spi_miso | input | 1 | Serial data in |
| irq_col | output | 1 | Collision interrupt request |
| irq_done | output | 1 | Completion interrupt request |

## Verification
Register reads are combinational, so a read shows the state left by the most recent clock edge. Every register side effect, every flag change and every interrupt change appears right after the edge that samples the strobe. The transfer end is checked to the exact cycle: busy is still set after edge 15*HALF-1 following the starting write, and done is set after edge 15*HALF. The driver queues each expected read value in the scoreboard before it drives the strobe. The monitor samples the read bus five nanoseconds after the falling edge of that same cycle, so each comparison lands between edges. Transfers that are not timed to the cycle are followed by a fixed idle wait longer than a transfer plus its trailing clock phase before anything is compared.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    localparam logic [7:0] ADDR_TX   = 8'h94;
    localparam logic [7:0] ADDR_RX   = 8'h95;
    localparam logic [7:0] ADDR_STAT = 8'hAB;
    localparam logic [7:0] ADDR_IEN  = 8'hAC;

    localparam int STAT_BUSY = 0;
    localparam int STAT_DONE = 1;
    localparam int STAT_COL  = 2;

    localparam int IEN_DONE = 0;
    localparam int IEN_COL  = 1;
endpackage

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
    parameter int DW   = 8,
    parameter int HALF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [DW-1:0] load_i,
    input  logic          miso_i,
    output logic          sclk_o,
    output logic          mosi_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] rx_o
);
    localparam int CW = $clog2(HALF + 1);
    localparam int BW = $clog2(DW);

    typedef struct packed {
        logic [DW-1:0] sh;
        logic          smp;
        logic [CW-1:0] cnt;
        logic [BW-1:0] bitc;
        logic          sclk;
        logic          busy;
    } sh_st_t;

    sh_st_t st_d, st_q;
    logic   phase_end;

    always_comb begin
        st_d      = st_q;
        done_o    = 1'b0;
        rx_o      = {st_q.sh[DW-2:0], miso_i};
        phase_end = (st_q.cnt == CW'(HALF - 1));
        if (start_i && !st_q.busy) begin
            // start: load, clock low, restart divider (cuts any trailing phase)
            st_d.sh   = load_i;
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.bitc = '0;
            st_d.sclk = 1'b0;
        end else if (st_q.busy) begin
            if (phase_end) begin
                st_d.cnt = '0;
                if (!st_q.sclk) begin
                    // rising edge: sample
                    st_d.sclk = 1'b1;
                    st_d.smp  = miso_i;
                    if (st_q.bitc == BW'(DW - 1)) begin
                        done_o    = 1'b1;
                        st_d.busy = 1'b0;
                    end
                end else begin
                    // falling edge: shift next bit out
                    st_d.sclk = 1'b0;
                    st_d.sh   = {st_q.sh[DW-2:0], st_q.smp};
                    st_d.bitc = st_q.bitc + 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (st_q.sclk) begin
            // trailing high phase after the last sample
            if (phase_end) begin
                st_d.sclk = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sclk_o = st_q.sclk;
    assign mosi_o = st_q.sh[DW-1];
    assign busy_o = st_q.busy;
endmodule

// File: rtl/ssp_flags.sv
module ssp_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic stat_rd_i,
    input  logic stat_wr_i,
    input  logic wr_col_bit_i,
    input  logic wr_done_bit_i,
    input  logic tx_wr_i,
    input  logic rx_rd_i,
    input  logic any_acc_i,
    input  logic busy_i,
    input  logic done_evt_i,
    output logic col_o,
    output logic done_o
);
    typedef struct packed {
        logic arm;
        logic rx_seen;
        logic col;
        logic done;
    } fl_st_t;

    fl_st_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        // armed bit for the read-then-access clear path
        if (stat_rd_i)      fl_d.arm = 1'b1;
        else if (any_acc_i) fl_d.arm = 1'b0;

        if (done_evt_i)   fl_d.rx_seen = 1'b0;
        else if (rx_rd_i) fl_d.rx_seen = 1'b1;

        // collision: clear paths first, set wins
        if ((stat_wr_i && !wr_col_bit_i) || (tx_wr_i && fl_q.arm))
            fl_d.col = 1'b0;
        if (tx_wr_i && busy_i)
            fl_d.col = 1'b1;

        // done: clear paths first, set wins
        if ((stat_wr_i && !wr_done_bit_i && fl_q.rx_seen) || (rx_rd_i && fl_q.arm))
            fl_d.done = 1'b0;
        if (done_evt_i)
            fl_d.done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign col_o  = fl_q.col;
    assign done_o = fl_q.done;
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int DW   = 8,
    parameter int HALF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          spi_sclk,
    output logic          spi_mosi,
    input  logic          spi_miso,
    output logic          irq_col,
    output logic          irq_done
);
    typedef struct packed {
        logic [DW-1:0] tx_hold;
        logic [DW-1:0] rxb;
        logic [1:0]    ien;
    } reg_st_t;

    reg_st_t rg_d, rg_q;

    logic          sel_tx, sel_rx, sel_stat, sel_ien;
    logic          tx_wr, rx_rd, stat_rd, stat_wr, ien_wr, any_acc;
    logic          busy, done_evt, col_flag, done_flag;
    logic [DW-1:0] rx_word;

    always_comb begin
        sel_tx   = (bus_addr == ADDR_TX);
        sel_rx   = (bus_addr == ADDR_RX);
        sel_stat = (bus_addr == ADDR_STAT);
        sel_ien  = (bus_addr == ADDR_IEN);
        tx_wr    = bus_wr && sel_tx;
        rx_rd    = bus_rd && sel_rx;
        stat_rd  = bus_rd && sel_stat;
        stat_wr  = bus_wr && sel_stat;
        ien_wr   = bus_wr && sel_ien;
        any_acc  = (bus_rd || bus_wr) && (sel_tx || sel_rx || sel_stat || sel_ien);
    end

    ssp_shifter #(.DW(DW), .HALF(HALF)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tx_wr),
        .load_i  (bus_wdata),
        .miso_i  (spi_miso),
        .sclk_o  (spi_sclk),
        .mosi_o  (spi_mosi),
        .busy_o  (busy),
        .done_o  (done_evt),
        .rx_o    (rx_word)
    );

    ssp_flags u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .stat_rd_i     (stat_rd),
        .stat_wr_i     (stat_wr),
        .wr_col_bit_i  (bus_wdata[STAT_COL]),
        .wr_done_bit_i (bus_wdata[STAT_DONE]),
        .tx_wr_i       (tx_wr),
        .rx_rd_i       (rx_rd),
        .any_acc_i     (any_acc),
        .busy_i        (busy),
        .done_evt_i    (done_evt),
        .col_o         (col_flag),
        .done_o        (done_flag)
    );

    always_comb begin
        rg_d = rg_q;
        if (tx_wr)    rg_d.tx_hold = bus_wdata;
        if (done_evt) rg_d.rxb     = rx_word;
        if (ien_wr)   rg_d.ien     = {bus_wdata[IEN_COL], bus_wdata[IEN_DONE]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_tx)        bus_rdata = rg_q.tx_hold;
        else if (sel_rx)   bus_rdata = rg_q.rxb;
        else if (sel_stat) bus_rdata = {{(DW-3){1'b0}}, col_flag, done_flag, busy};
        else if (sel_ien)  bus_rdata = {{(DW-2){1'b0}}, rg_q.ien};
    end

    assign irq_col  = col_flag  && rg_q.ien[1];
    assign irq_done = done_flag && rg_q.ien[0];
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker
    import ssp_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [7:0]    bus_addr,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [DW-1:0] bus_rdata,
    input logic          spi_sclk,
    input logic          irq_col,
    input logic          irq_done,
    input logic          busy,
    input logic          done_evt,
    input logic          col_flag,
    input logic          done_flag,
    input logic [1:0]    ien
);
    p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_TX && !busy) |=> (busy && !spi_sclk));

    p_done_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> (done_flag && !busy));

    p_col_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_TX && busy) |=> col_flag);

    p_no_sw_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!col_flag && !(bus_wr && bus_addr == ADDR_TX)) |=> !col_flag);

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ien[0] |-> !irq_done) and (!ien[1] |-> !irq_col)));

    p_stat_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_STAT) |-> (bus_rdata[STAT_BUSY] == busy));

    p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_STAT) |-> (bus_rdata[DW-1:3] == '0));
endmodule

bind sync_serial_port ssp_checker #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .spi_sclk  (spi_sclk),
    .irq_col   (irq_col),
    .irq_done  (irq_done),
    .busy      (busy),
    .done_evt  (done_evt),
    .col_flag  (col_flag),
    .done_flag (done_flag),
    .ien       (rg_q.ien)
);

// File: tb/sim_sync_serial_port.sv
module sim_sync_serial_port;
    localparam int DW   = 8;
    localparam int HALF = 2;
    localparam logic [7:0] A_TX = 8'h94, A_RX = 8'h95, A_ST = 8'hAB, A_IE = 8'hAC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          spi_sclk, spi_mosi, spi_miso, irq_col, irq_done;
    logic [1:0]    miso_mode = 2'd0;

    int n_vec = 0;
    int n_bad = 0;

    typedef struct {
        logic [DW-1:0] exp;
        string         tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    assign spi_miso = (miso_mode == 2'd0) ? spi_mosi : (miso_mode == 2'd1);

    sync_serial_port #(.DW(DW), .HALF(HALF)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .spi_sclk  (spi_sclk),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .irq_col   (irq_col),
        .irq_done  (irq_done)
    );

    task automatic check(input logic [DW-1:0] got, input logic [DW-1:0] exp, input string tag);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // monitor: compare every read strobe against the scoreboard head
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (bus_rd && sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                check(bus_rdata, it.exp, it.tag);
            end
        end
    end

    task automatic rd(input logic [7:0] a, input logic [DW-1:0] exp, input string tag);
        exp_t it;
        it.exp = exp;
        it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic chk_irq(input logic col_e, input logic done_e, input string tag);
        @(negedge clk);
        #5;
        check({6'd0, irq_col, irq_done}, {6'd0, col_e, done_e}, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(A_ST, 8'h00, "R1 status");
        rd(A_RX, 8'h00, "R1 rx");
        rd(A_TX, 8'h00, "R1 tx");
        rd(A_IE, 8'h00, "R1 enable");
        chk_irq(1'b0, 1'b0, "R1 irq");

        // R2/R3 timed loopback transfer, interrupts disabled
        wr(A_TX, 8'hA5);
        idle(15 * HALF - 1);
        rd(A_ST, 8'h01, "R3 busy still set");
        rd(A_ST, 8'h02, "R3 done at edge 15*HALF, R11 reserved");
        chk_irq(1'b0, 1'b0, "R9 done gated off");
        wr(A_IE, 8'h01);
        chk_irq(1'b0, 1'b1, "R9 done enabled");
        rd(A_ST, 8'h02, "R8 arm read");
        rd(A_RX, 8'hA5, "R2 loopback byte");
        rd(A_ST, 8'h00, "R8 done cleared by status+rx read");
        chk_irq(1'b0, 1'b0, "R9 done irq drops");

        // R4/R5 collision
        wr(A_IE, 8'h03);
        wr(A_TX, 8'h3C);
        wr(A_TX, 8'h99);
        rd(A_ST, 8'h05, "R4 collision while busy");
        rd(A_TX, 8'h99, "R4 rejected byte readable");
        chk_irq(1'b1, 1'b0, "R9 collision irq");
        idle(40);
        rd(A_ST, 8'h06, "R4 flags after transfer");
        rd(A_RX, 8'h3C, "R4 original byte delivered");
        rd(A_ST, 8'h04, "R8 done cleared, collision kept");
        wr(A_ST, 8'h04);
        rd(A_ST, 8'h04, "R5 writing one keeps collision");
        wr(A_ST, 8'h00);
        rd(A_ST, 8'h00, "R5 collision cleared by zero");
        chk_irq(1'b0, 1'b0, "R5 irq cleared");

        // R6/R10 status read then transmit write; overrun silent
        wr(A_TX, 8'h11);
        wr(A_TX, 8'h22);
        idle(40);
        rd(A_ST, 8'h06, "R6 flags before clear");
        wr(A_TX, 8'h77);
        rd(A_ST, 8'h03, "R6 collision cleared by status+tx write");
        idle(40);
        rd(A_ST, 8'h02, "R10 no overrun flag");
        rd(A_RX, 8'h77, "R10 rx overwritten");

        // R7/R8 zero-write needs prior rx read; broken arm
        wr(A_TX, 8'h5A);
        idle(40);
        wr(A_ST, 8'h00);
        rd(A_ST, 8'h02, "R7 zero write without rx read ignored");
        rd(A_IE, 8'h03, "R8 intervening access");
        rd(A_RX, 8'h5A, "R8 rx read after broken arm");
        rd(A_ST, 8'h02, "R8 done kept when arm broken");
        rd(A_IE, 8'h03, "R7 disarm");
        wr(A_ST, 8'h00);
        rd(A_ST, 8'h00, "R7 zero write after rx read clears");

        // R2 MSB-first receive with constant miso
        miso_mode = 2'd1;
        wr(A_TX, 8'h00);
        idle(40);
        rd(A_ST, 8'h02, "R2 done ones");
        rd(A_RX, 8'hFF, "R2 miso high");
        miso_mode = 2'd2;
        wr(A_TX, 8'hFF);
        idle(40);
        rd(A_ST, 8'h02, "R2 done zeros");
        rd(A_RX, 8'h00, "R2 miso low");

        idle(2);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule